// File: doc/BRIEF.md
# Boot Stage Verification Gate

This block sequences a four-stage boot chain: root stage, bootloader, operating system or hypervisor, and application, always in that order. For each stage it asks an external verifier for a verdict. The verdict is a signature flag, a policy flag and the candidate image version, handed over through a request/valid handshake. The block then classifies the outcome and compares the version against a monotonic anti-rollback counter. Because of that comparison, an older image is refused even when its signature is valid.

Each verdict produces one audit record. The record is pushed out over a valid/ready port and holds the stage, the counter value before the decision, the candidate version, both verifier flags, the outcome and a reason code. The sequencer waits while the consumer holds ready low.

In enforce mode, a rejected stage is never released and the chain halts. In measure-only mode, every stage is released and the record still carries the true verdict. The counter advances only on a clean acceptance of a higher version. A verifier that stays silent for the configured wait limit counts as a reject.

Top module: `boot_gate`

## Requirements
- R1: After reset, no verdict request, audit record, release, done or halt is asserted, and the counter output equals the reset value CTR_RESET (default 2).
- R2: A start pulse in the idle state begins the chain. Stages 0, 1, 2 and 3 are requested and released strictly in that order. After stage 3 is released, done_o is asserted.
- R3: In enforce mode (enforce_i = 1, sampled at start), a stage with a non-zero reason is not released, and halt_o is asserted with no further requests.
- R4: In measure-only mode (enforce_i = 0 at start), every stage is released with pass = 1, and the record still carries the actual reason code.
- R5: With a valid signature, a candidate version below the counter gives reason 2 (downgrade).
- R6: With a valid signature and a version not below the counter, a policy-denied flag gives reason 3.
- R7: An invalid signature gives reason 1. It takes priority over downgrade and policy denial.
- R8: Each record carries the stage index, the counter value before the decision (from), the candidate version (to), the signature flag, the policy flag, pass and the reason. Reason 0 means accepted.
- R9: The counter rises to the candidate version only when a stage is accepted with reason 0 and a higher version. An equal or lower version leaves it unchanged, and the counter never decreases.
- R10: If no verdict arrives within WAIT_LIMIT cycles of the request (default 16), the record has reason 4, with both flags and the version at 0. A verdict on the last cycle of the window is still taken.
- R11: While a record is offered and ready is low, the record stays stable, nothing is released and the chain does not advance.
- R12: A verdict strobe outside a pending request is ignored. A change of enforce_i after start has no effect on the running chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the chain (accepted when idle) |
| enforce_i | input | 1 | 1 = enforce, 0 = measure-only; sampled at start |
| vreq_o | output | 1 | Verdict requested for current stage |
| vstage_o | output | 2 | Stage being verified |
| vvalid_i | input | 1 | Verdict strobe |
| sig_ok_i | input | 1 | Signature valid |
| pol_ok_i | input | 1 | Policy allows image |
| img_ver_i | input | 8 | Candidate image version |
| rel_o | output | 1 | One-cycle stage release pulse |
| rel_stage_o | output | 2 | Stage being released |
| aud_valid_o | output | 1 | Audit record offered |
| aud_ready_i | input | 1 | Audit consumer ready |
| aud_stage_o | output | 2 | Record: stage |
| aud_from_o | output | 8 | Record: counter before decision |
| aud_to_o | output | 8 | Record: candidate version |
| aud_sig_o | output | 1 | Record: signature flag |
| aud_pol_o | output | 1 | Record: policy flag |
| aud_pass_o | output | 1 | Record: stage released |
| aud_reason_o | output | 3 | Record: reason code |
| ctr_o | output | 8 | Monotonic version counter |
| done_o | output | 1 | All stages released |
| halt_o | output | 1 | Chain stopped on enforced reject |

## Verification
Two events can fall in the same cycle: a verdict strobe and the expiry of the wait window. The bench holds the verdict back until the last cycle of the window, expects the verdict to win, and checks the resulting reason 0 and the counter update. A separate run stays silent for one more cycle and expects reason 4. A second collision puts several causes in one verdict: a bad signature together with a downgrade version and a policy denial. Only reason 1 may appear.

// File: rtl/boot_gate_pkg.sv
package boot_gate_pkg;
  typedef enum logic [2:0] {
    RSN_OK      = 3'd0,
    RSN_BADSIG  = 3'd1,
    RSN_DOWN    = 3'd2,
    RSN_POLICY  = 3'd3,
    RSN_TIMEOUT = 3'd4
  } reason_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOG,
    ST_DONE,
    ST_HALT
  } gate_st_t;
endpackage

// File: rtl/bg_vers_ctr.sv
module bg_vers_ctr #(
  parameter int VER_W = 8,
  parameter logic [VER_W-1:0] CTR_RESET = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic [VER_W-1:0] adv_val,
  output logic [VER_W-1:0] cnt_o
);
  logic [VER_W-1:0] cnt_q;
  logic             raise;

  assign raise = adv_en && (adv_val > cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= CTR_RESET;
    else if (raise) cnt_q <= adv_val;
  end

  assign cnt_o = cnt_q;

  // R9: counter is monotonic
  p_ctr_never_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/bg_wait_timer.sv
module bg_wait_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  assign expire = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (!expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bg_verdict_eval.sv
module bg_verdict_eval
  import boot_gate_pkg::*;
#(
  parameter int VER_W = 8
) (
  input  logic             sig_ok,
  input  logic             pol_ok,
  input  logic [VER_W-1:0] ver,
  input  logic [VER_W-1:0] ctr,
  output reason_t          reason
);
  always_comb begin
    if (!sig_ok)         reason = RSN_BADSIG;
    else if (ver < ctr)  reason = RSN_DOWN;
    else if (!pol_ok)    reason = RSN_POLICY;
    else                 reason = RSN_OK;
  end
endmodule

// File: rtl/boot_gate.sv
module boot_gate
  import boot_gate_pkg::*;
#(
  parameter int VER_W      = 8,
  parameter int STAGES     = 4,
  parameter int WAIT_LIMIT = 16,
  parameter logic [VER_W-1:0] CTR_RESET = 8'd2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic                      enforce_i,
  output logic                      vreq_o,
  output logic [$clog2(STAGES)-1:0] vstage_o,
  input  logic                      vvalid_i,
  input  logic                      sig_ok_i,
  input  logic                      pol_ok_i,
  input  logic [VER_W-1:0]          img_ver_i,
  output logic                      rel_o,
  output logic [$clog2(STAGES)-1:0] rel_stage_o,
  output logic                      aud_valid_o,
  input  logic                      aud_ready_i,
  output logic [$clog2(STAGES)-1:0] aud_stage_o,
  output logic [VER_W-1:0]          aud_from_o,
  output logic [VER_W-1:0]          aud_to_o,
  output logic                      aud_sig_o,
  output logic                      aud_pol_o,
  output logic                      aud_pass_o,
  output logic [2:0]                aud_reason_o,
  output logic [VER_W-1:0]          ctr_o,
  output logic                      done_o,
  output logic                      halt_o
);
  localparam int SW = $clog2(STAGES);
  localparam logic [SW-1:0] LAST_STG = SW'(STAGES - 1);

  gate_st_t         state_q, state_d;
  logic [SW-1:0]    stage_q, stage_d;
  logic             mode_q;
  reason_t          eval_rsn, rec_rsn_q;
  logic             rec_sig_q, rec_pol_q;
  logic [VER_W-1:0] rec_from_q, rec_to_q, ctr;
  logic             rel_q, rel_d;
  logic [SW-1:0]    rel_stg_q;
  logic             tmo, cap_en, cap_tmo, adv_en, pass, mode_ld;

  bg_verdict_eval #(.VER_W(VER_W)) u_eval (
    .sig_ok(sig_ok_i), .pol_ok(pol_ok_i), .ver(img_ver_i), .ctr(ctr), .reason(eval_rsn)
  );

  bg_wait_timer #(.LIMIT(WAIT_LIMIT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_WAIT), .expire(tmo)
  );

  bg_vers_ctr #(.VER_W(VER_W), .CTR_RESET(CTR_RESET)) u_ctr (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .adv_val(rec_to_q), .cnt_o(ctr)
  );

  assign pass    = (rec_rsn_q == RSN_OK) || !mode_q;
  assign mode_ld = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    cap_en  = 1'b0;
    cap_tmo = 1'b0;
    adv_en  = 1'b0;
    rel_d   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (vvalid_i) begin
          cap_en  = 1'b1;
          state_d = ST_LOG;
        end else if (tmo) begin
          cap_en  = 1'b1;
          cap_tmo = 1'b1;
          state_d = ST_LOG;
        end
      end
      ST_LOG: begin
        if (aud_ready_i) begin
          rel_d  = pass;
          adv_en = (rec_rsn_q == RSN_OK);
          if (!pass)                    state_d = ST_HALT;
          else if (stage_q == LAST_STG) state_d = ST_DONE;
          else begin
            stage_d = stage_q + 1'b1;
            state_d = ST_WAIT;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      stage_q   <= '0;
      rel_q     <= 1'b0;
      rel_stg_q <= '0;
    end else begin
      state_q   <= state_d;
      stage_q   <= stage_d;
      rel_q     <= rel_d;
      rel_stg_q <= stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= 1'b1;
    else if (mode_ld) mode_q <= enforce_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_rsn_q  <= RSN_OK;
      rec_sig_q  <= 1'b0;
      rec_pol_q  <= 1'b0;
      rec_from_q <= '0;
      rec_to_q   <= '0;
    end else if (cap_en) begin
      rec_rsn_q  <= cap_tmo ? RSN_TIMEOUT : eval_rsn;
      rec_sig_q  <= !cap_tmo && sig_ok_i;
      rec_pol_q  <= !cap_tmo && pol_ok_i;
      rec_from_q <= ctr;
      rec_to_q   <= cap_tmo ? '0 : img_ver_i;
    end
  end

  assign vreq_o       = (state_q == ST_WAIT);
  assign vstage_o     = stage_q;
  assign rel_o        = rel_q;
  assign rel_stage_o  = rel_stg_q;
  assign aud_valid_o  = (state_q == ST_LOG);
  assign aud_stage_o  = stage_q;
  assign aud_from_o   = rec_from_q;
  assign aud_to_o     = rec_to_q;
  assign aud_sig_o    = rec_sig_q;
  assign aud_pol_o    = rec_pol_q;
  assign aud_pass_o   = pass;
  assign aud_reason_o = rec_rsn_q;
  assign ctr_o        = ctr;
  assign done_o       = (state_q == ST_DONE);
  assign halt_o       = (state_q == ST_HALT);

  // R11: offered record held stable under backpressure
  p_aud_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid_o && !aud_ready_i |=> aud_valid_o && $stable(aud_reason_o)
      && $stable(aud_to_o) && $stable(aud_stage_o) && $stable(aud_from_o));

  // R3: enforce mode releases only clean stages
  p_enf_release_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rel_o && mode_q |-> rec_rsn_q == RSN_OK);

  // R3: halt only reachable in enforce mode
  p_halt_enforce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_o) |-> mode_q);

  // R7: a record with bad signature never claims another cause
  p_badsig_reason_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid_o && !aud_sig_o |-> aud_reason_o == RSN_BADSIG || aud_reason_o == RSN_TIMEOUT);

  // R5: signed older image is reported as downgrade
  p_downgrade_r5: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid_o && aud_sig_o && (aud_to_o < aud_from_o) |-> aud_reason_o == RSN_DOWN);

  // R9: counter moves only together with an accepted release
  p_ctr_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_o != $past(ctr_o)) |-> rel_o && rec_rsn_q == RSN_OK);
endmodule

// File: tb/boot_gate_tb.sv
module boot_gate_tb_top;
  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rst_n, start_i, enforce_i, vvalid_i, sig_ok_i, pol_ok_i, aud_ready_i;
  logic [7:0] img_ver_i;
  logic vreq_o, rel_o, aud_valid_o, aud_sig_o, aud_pol_o, aud_pass_o, done_o, halt_o;
  logic [1:0] vstage_o, rel_stage_o, aud_stage_o;
  logic [7:0] aud_from_o, aud_to_o, ctr_o;
  logic [2:0] aud_reason_o;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  boot_gate dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .enforce_i(enforce_i),
    .vreq_o(vreq_o), .vstage_o(vstage_o), .vvalid_i(vvalid_i), .sig_ok_i(sig_ok_i),
    .pol_ok_i(pol_ok_i), .img_ver_i(img_ver_i), .rel_o(rel_o), .rel_stage_o(rel_stage_o),
    .aud_valid_o(aud_valid_o), .aud_ready_i(aud_ready_i), .aud_stage_o(aud_stage_o),
    .aud_from_o(aud_from_o), .aud_to_o(aud_to_o), .aud_sig_o(aud_sig_o),
    .aud_pol_o(aud_pol_o), .aud_pass_o(aud_pass_o), .aud_reason_o(aud_reason_o),
    .ctr_o(ctr_o), .done_o(done_o), .halt_o(halt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start_i = 1'b0; enforce_i = 1'b1; vvalid_i = 1'b0;
    sig_ok_i = 1'b0; pol_ok_i = 1'b0; img_ver_i = '0; aud_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic begin_chain(input logic enf);
    enforce_i = enf; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // verdict now, check the record, then the release one cycle later
  task automatic step(input string req, input int stg, input logic s, input logic p,
                      input int ver, input int rsn, input int ps, input int from);
    check({req, " request"}, vreq_o, 1);
    sig_ok_i = s; pol_ok_i = p; img_ver_i = 8'(ver); vvalid_i = 1'b1;
    @(negedge clk);
    vvalid_i = 1'b0;
    check({req, " R8 valid"}, aud_valid_o, 1);
    check({req, " R8 stage"}, aud_stage_o, stg);
    check({req, " R8 from"}, aud_from_o, from);
    check({req, " R8 to"}, aud_to_o, ver);
    check({req, " R8 sig"}, aud_sig_o, s);
    check({req, " R8 pol"}, aud_pol_o, p);
    check({req, " reason"}, aud_reason_o, rsn);
    check({req, " pass"}, aud_pass_o, ps);
    @(negedge clk);
    check({req, " release"}, rel_o, ps);
    if (ps) check({req, " R2 release stage"}, rel_stage_o, stg);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 req", vreq_o, 0);
    check("R1 audit", aud_valid_o, 0);
    check("R1 release", rel_o, 0);
    check("R1 done", done_o, 0);
    check("R1 halt", halt_o, 0);
    check("R1 counter", ctr_o, 2);
  endtask

  task automatic t_good_chain();
    do_reset();
    begin_chain(1'b1);
    step("R2 s0", 0, 1, 1, 3, 0, 1, 2);
    check("R9 raise", ctr_o, 3);
    step("R2 s1", 1, 1, 1, 4, 0, 1, 3);
    step("R9 equal s2", 2, 1, 1, 4, 0, 1, 4);
    check("R9 equal keeps", ctr_o, 4);
    step("R2 s3", 3, 1, 1, 7, 0, 1, 4);
    check("R2 done", done_o, 1);
    check("R2 no req after done", vreq_o, 0);
    check("R9 final", ctr_o, 7);
  endtask

  task automatic t_enforce_rejects();
    do_reset();
    begin_chain(1'b1);
    step("R2 s0", 0, 1, 1, 5, 0, 1, 2);
    enforce_i = 1'b0;  // R12: ignored after start
    step("R7 R12 s1", 1, 0, 1, 6, 1, 0, 5);
    check("R3 halt", halt_o, 1);
    check("R3 no req", vreq_o, 0);
    check("R9 unchanged", ctr_o, 5);
    do_reset();
    begin_chain(1'b1);
    step("R5 s0", 0, 1, 1, 1, 2, 0, 2);
    check("R3 halt down", halt_o, 1);
    check("R9 not lowered", ctr_o, 2);
    do_reset();
    begin_chain(1'b1);
    step("R6 s0", 0, 1, 0, 5, 3, 0, 2);
    check("R9 policy no raise", ctr_o, 2);
    do_reset();
    begin_chain(1'b1);
    step("R7 prio s0", 0, 0, 0, 1, 1, 0, 2);
  endtask

  task automatic t_measure();
    do_reset();
    begin_chain(1'b0);
    step("R4 R5 s0", 0, 1, 1, 1, 2, 1, 2);
    check("R9 measure down", ctr_o, 2);
    step("R4 R7 s1", 1, 0, 1, 8, 1, 1, 2);
    check("R9 badsig no raise", ctr_o, 2);
    step("R4 s2", 2, 1, 1, 9, 0, 1, 2);
    check("R9 raise", ctr_o, 9);
    for (int i = 0; i < LIM; i++) @(negedge clk);
    check("R10 R4 timeout valid", aud_valid_o, 1);
    check("R10 reason", aud_reason_o, 4);
    check("R10 to zero", aud_to_o, 0);
    check("R10 sig zero", aud_sig_o, 0);
    check("R4 pass", aud_pass_o, 1);
    @(negedge clk);
    check("R4 release s3", rel_o, 1);
    check("R2 done", done_o, 1);
  endtask

  task automatic t_timeout_edge();
    do_reset();
    begin_chain(1'b1);
    for (int i = 0; i < LIM - 1; i++) @(negedge clk);
    check("R10 still waiting", aud_valid_o, 0);
    step("R10 last cycle verdict", 0, 1, 1, 6, 0, 1, 2);
    check("R10 counter", ctr_o, 6);
    for (int i = 0; i < LIM - 1; i++) @(negedge clk);
    check("R10 waiting s1", aud_valid_o, 0);
    @(negedge clk);
    check("R10 timeout s1", aud_valid_o, 1);
    check("R10 reason s1", aud_reason_o, 4);
    @(negedge clk);
    check("R3 R10 halt", halt_o, 1);
    check("R3 no release", rel_o, 0);
  endtask

  task automatic t_stall_and_ignore();
    do_reset();
    sig_ok_i = 1'b1; pol_ok_i = 1'b1; img_ver_i = 8'd50; vvalid_i = 1'b1;
    @(negedge clk);
    vvalid_i = 1'b0;
    check("R12 idle verdict no audit", aud_valid_o, 0);
    check("R12 idle verdict counter", ctr_o, 2);
    begin_chain(1'b1);
    aud_ready_i = 1'b0;
    sig_ok_i = 1'b1; pol_ok_i = 1'b1; img_ver_i = 8'd4; vvalid_i = 1'b1;
    @(negedge clk);
    vvalid_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R11 held", aud_valid_o, 1);
      check("R11 to stable", aud_to_o, 4);
      check("R11 no release", rel_o, 0);
      check("R11 counter", ctr_o, 2);
    end
    aud_ready_i = 1'b1;
    @(negedge clk);
    check("R11 release", rel_o, 1);
    check("R11 counter after", ctr_o, 4);
    check("R2 next stage", vstage_o, 1);
  endtask

  initial begin
    t_reset();
    t_good_chain();
    t_enforce_rejects();
    t_measure();
    t_timeout_edge();
    t_stall_and_ignore();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule